// File: doc/BRIEF.md
# Cached Store Replay Queue

This block keeps an ordered record of stores that targeted cacheable memory, so that a later cache-line invalidation can push those stores out to memory before the line is thrown away. Every command carries an address, a data word and a cacheable qualifier. A record command appends the store at the tail when it is cacheable. A discard command drops everything held. An invalidate command names an address. Every held store whose address lies in the same 32-byte line is written to memory, oldest first, through a valid/ready write port, and is then taken out of the queue.

Stores outside that line keep their places. The queue closes the gaps left by removed entries, so the survivors stay contiguous and in their original relative order. While an invalidate scan runs, the block reports busy and ignores any new command. A cacheable store that finds the queue full is dropped and sets a sticky overflow flag.

Top module: `store_replay_queue`

## Requirements
- R1: After reset, `count` is 0 and `busy`, `wrValid` and `overflow` are all 0.
- R2: A command is taken when `cmdValid` is 1 and `busy` is 0. `cmdOp` encodes the command: 0 is record, 1 is discard, 2 is invalidate, and 3 has no effect. A taken record with `cmdCacheable`=1 and room left appends {`cmdAddr`, `cmdData`} at the tail, and `count` rises by one on the next clock edge.
- R3: A taken record with `cmdCacheable`=0 leaves `count` and the held stores unchanged.
- R4: A taken cacheable record that arrives when `count` equals DEPTH is not stored. On the next edge `overflow` becomes 1, and it stays 1 until a discard is taken.
- R5: A taken discard sets `count` to 0 and clears `overflow` on the next edge.
- R6: A taken invalidate writes every held store whose address matches `cmdAddr` in bits 31:5 to the write port. Each write carries that store's own address and data, and the writes come out in the order the stores were recorded. Every written entry is removed, so `count` falls by one on each edge where `wrValid` and `wrReady` are both 1.
- R7: Held stores outside the invalidated line stay in the queue in their original relative order, as seen in the order of later replays.
- R8: While `wrValid` is 1 and `wrReady` is 0, `wrValid`, `wrAddr` and `wrData` hold steady on the next cycle.
- R9: From the edge that takes an invalidate until the scan ends, `busy` is 1. Commands offered while `busy` is 1 have no effect, and `wrValid` is only ever 1 while `busy` is 1.
- R10: An invalidate that matches no held store issues no write and ends with `count` unchanged. A command with code 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Command offered this cycle |
| cmdOp | input | 2 | Command code: 0 record, 1 discard, 2 invalidate, 3 none |
| cmdAddr | input | 32 | Store address, or the line address for an invalidate |
| cmdData | input | 32 | Store data for a record |
| cmdCacheable | input | 1 | The record targets cacheable memory |
| busy | output | 1 | An invalidate scan is running and commands are ignored |
| overflow | output | 1 | Sticky: a cacheable store was dropped because the queue was full |
| count | output | $clog2(DEPTH+1) | Number of held stores |
| wrValid | output | 1 | Memory write request |
| wrAddr | output | 32 | Memory write address |
| wrData | output | 32 | Memory write data |
| wrReady | input | 1 | Memory accepts the write this cycle |

## Verification
The bench builds the queue with DEPTH=4 and the 32-byte line size. A queue that small fills after four records, so the overflow path and an invalidate over a completely full queue both come up within a few commands. Stores are placed on both sides of a line boundary, so the bit 5 masking is tested at its edge. The write port's ready is driven with a pseudo-random pattern and with a long stall, which tests holding the request steady and removing an entry from the middle of the queue while it closes up.

// File: rtl/sbq_pkg.sv
package sbq_pkg;
  parameter int ADDR_W = 32;
  parameter int DATA_W = 32;

  typedef enum logic [1:0] {
    OP_RECORD  = 2'd0,
    OP_DISCARD = 2'd1,
    OP_INVAL   = 2'd2,
    OP_NONE    = 2'd3
  } sbq_op_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } sbq_entry_t;

  // strobes from control to datapath
  typedef struct packed {
    logic push;
    logic clear;
    logic remove;
  } sbq_strobe_t;
endpackage

// File: rtl/sbq_datapath.sv
module sbq_datapath
  import sbq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  sbq_strobe_t      strobe,
  input  logic [CNT_W-1:0] scanIdx,
  input  sbq_entry_t       newEntry,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output sbq_entry_t       rdEntry
);
  sbq_entry_t slots [DEPTH];

  assign full = (count == CNT_W'(DEPTH));

  // read port at the scan position
  always_comb begin
    if (scanIdx < CNT_W'(DEPTH)) rdEntry = slots[scanIdx[IDX_W-1:0]];
    else                         rdEntry = '0;
  end

  // occupancy
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               count <= '0;
    else if (strobe.clear)   count <= '0;
    else if (strobe.push)    count <= count + 1'b1;
    else if (strobe.remove)  count <= count - 1'b1;
  end

  // storage: append at tail, close the gap on removal
  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    if (g < DEPTH - 1) begin : gShift
      always_ff @(posedge clk) begin
        if (strobe.push && count == CNT_W'(g))
          slots[g] <= newEntry;
        else if (strobe.remove && CNT_W'(g) >= scanIdx)
          slots[g] <= slots[g+1];
      end
    end else begin : gLast
      always_ff @(posedge clk) begin
        if (strobe.push && count == CNT_W'(g))
          slots[g] <= newEntry;
      end
    end
  end
endmodule

// File: rtl/sbq_control.sv
module sbq_control
  import sbq_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int LINE_BYTES = 32,
  localparam int CNT_W    = $clog2(DEPTH + 1),
  localparam int LINE_LSB = $clog2(LINE_BYTES),
  localparam int TAG_W    = ADDR_W - LINE_LSB
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  sbq_op_e           cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              cmdCacheable,
  input  logic [CNT_W-1:0]  count,
  input  logic              full,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              wrReady,
  output sbq_strobe_t       strobe,
  output logic [CNT_W-1:0]  scanIdx,
  output logic              busy,
  output logic              overflow,
  output logic              wrValid
);
  typedef enum logic {ST_IDLE, ST_SCAN} state_e;

  state_e           state;
  logic [TAG_W-1:0] lineTag;
  logic             accept;
  logic             cachedRecord;
  logic             inRange;
  logic             hit;

  always_comb begin
    accept        = cmdValid && (state == ST_IDLE);
    cachedRecord  = accept && (cmdOp == OP_RECORD) && cmdCacheable;
    inRange       = scanIdx < count;
    hit           = inRange && (rdAddr[ADDR_W-1:LINE_LSB] == lineTag);
    wrValid       = (state == ST_SCAN) && hit;
    strobe.push   = cachedRecord && !full;
    strobe.clear  = accept && (cmdOp == OP_DISCARD);
    strobe.remove = wrValid && wrReady;
  end

  assign busy = (state == ST_SCAN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      scanIdx  <= '0;
      lineTag  <= '0;
      overflow <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept && cmdOp == OP_INVAL) begin
            state   <= ST_SCAN;
            scanIdx <= '0;
            lineTag <= cmdAddr[ADDR_W-1:LINE_LSB];
          end
          if (cachedRecord && full) overflow <= 1'b1;
          if (strobe.clear)         overflow <= 1'b0;
        end
        ST_SCAN: begin
          // a hit stays on its slot until written; the next entry shifts in
          if (!inRange)  state   <= ST_IDLE;
          else if (!hit) scanIdx <= scanIdx + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/store_replay_queue.sv
module store_replay_queue
  import sbq_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int LINE_BYTES = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              cmdCacheable,
  output logic              busy,
  output logic              overflow,
  output logic [CNT_W-1:0]  count,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  input  logic              wrReady
);
  sbq_strobe_t      strobe;
  logic [CNT_W-1:0] scanIdx;
  logic             full;
  sbq_entry_t       rdEntry;
  sbq_entry_t       newEntry;

  assign newEntry = '{addr: cmdAddr, data: cmdData};
  assign wrAddr   = rdEntry.addr;
  assign wrData   = rdEntry.data;

  sbq_control #(.DEPTH(DEPTH), .LINE_BYTES(LINE_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(sbq_op_e'(cmdOp)),
    .cmdAddr(cmdAddr), .cmdCacheable(cmdCacheable), .count(count), .full(full),
    .rdAddr(rdEntry.addr), .wrReady(wrReady), .strobe(strobe), .scanIdx(scanIdx),
    .busy(busy), .overflow(overflow), .wrValid(wrValid)
  );

  sbq_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .scanIdx(scanIdx),
    .newEntry(newEntry), .count(count), .full(full), .rdEntry(rdEntry)
  );
endmodule

// File: rtl/sbq_checker.sv
module sbq_checker
  import sbq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic [1:0]        cmdOp,
  input logic              cmdCacheable,
  input logic              busy,
  input logic              overflow,
  input logic [CNT_W-1:0]  count,
  input logic              wrValid,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              wrReady
);
  logic taken;
  assign taken = cmdValid && !busy;

  // R8
  write_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && !wrReady |=> wrValid && $stable(wrAddr) && $stable(wrData));

  // R9
  write_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> busy);

  // R9
  busy_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && !(wrValid && wrReady) |=> $stable(count));

  // R4
  count_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  // R4
  no_overflow_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    taken && cmdOp == 2'd0 && cmdCacheable && count == CNT_W'(DEPTH)
    |=> overflow && $stable(count));

  // R5
  discard_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    taken && cmdOp == 2'd1 |=> count == '0 && !overflow);

  // R3
  uncached_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    taken && cmdOp == 2'd0 && !cmdCacheable |=> $stable(count));

  // R6
  replay_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && wrReady |=> count == $past(count) - 1'b1);
endmodule

bind store_replay_queue sbq_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
  .cmdCacheable(cmdCacheable), .busy(busy), .overflow(overflow), .count(count),
  .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData), .wrReady(wrReady)
);

// File: tb/store_replay_queue_bench.sv
module store_replay_queue_bench;
  localparam int DEPTH = 4;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [1:0] cmdOp = 2'd3;
  logic [31:0] cmdAddr = '0;
  logic [31:0] cmdData = '0;
  logic cmdCacheable = 1'b0;
  logic busy, overflow, wrValid;
  logic [CNT_W-1:0] count;
  logic [31:0] wrAddr, wrData;
  logic wrReady = 1'b0;

  store_replay_queue #(.DEPTH(DEPTH), .LINE_BYTES(32)) u_store_replay_queue (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
    .cmdData(cmdData), .cmdCacheable(cmdCacheable), .busy(busy), .overflow(overflow),
    .count(count), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData), .wrReady(wrReady)
  );

  always #4 clk = ~clk;  // 125 MHz

  int nChecks = 0;
  int nFails  = 0;
  logic [63:0] model[$];
  logic [63:0] expQ[$];
  logic expOvf = 1'b0;
  int readyMode = 0;  // 0 always ready, 1 pseudo-random, 2 stalled
  logic [7:0] lfsr = 8'hA5;
  logic prevStall = 1'b0;
  logic [31:0] prevAddr = '0, prevData = '0;
  bit done = 0;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  // monitor: ready generation and scoreboard compare, all at negedge
  always @(negedge clk) begin
    if (rstN) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      wrReady = (readyMode == 0) ? 1'b1 : (readyMode == 1) ? (lfsr[0] | lfsr[2]) : 1'b0;
      if (prevStall)  // R8
        check("R8 hold", {wrValid, wrAddr, wrData}, {1'b1, prevAddr, prevData});
      if (wrValid) check("R9 valid only while busy", busy, 1'b1);
      if (wrValid && wrReady) begin
        if (expQ.size() == 0) check("R6 unexpected write", {wrAddr, wrData}, 64'hx);
        else check("R6 replay", {wrAddr, wrData}, expQ.pop_front());
      end
      prevStall = wrValid && !wrReady;
      prevAddr  = wrAddr;
      prevData  = wrData;
    end
  end

  task automatic sendCmd(logic [1:0] op, logic [31:0] a, logic [31:0] d, logic c);
    while (busy) @(negedge clk);
    cmdOp = op; cmdAddr = a; cmdData = d; cmdCacheable = c; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic record(logic [31:0] a, logic [31:0] d, logic c, string req);
    if (c) begin
      if (model.size() < DEPTH) model.push_back({a, d});
      else expOvf = 1'b1;
    end
    sendCmd(2'd0, a, d, c);
    check({req, " count"}, count, model.size());
    check({req, " overflow"}, overflow, expOvf);
  endtask

  // push expected writes, keep the rest in order
  task automatic planInval(logic [31:0] a);
    logic [63:0] keep[$];
    foreach (model[i]) begin
      if (model[i][63:37] == a[31:5]) expQ.push_back(model[i]);
      else keep.push_back(model[i]);
    end
    model = keep;
  endtask

  task automatic inval(logic [31:0] a, string req);
    planInval(a);
    sendCmd(2'd2, a, 32'h0, 1'b0);
    while (busy) @(negedge clk);
    check({req, " count"}, count, model.size());
    check({req, " all writes seen"}, expQ.size(), 0);
  endtask

  task automatic discard();
    model.delete();
    expOvf = 1'b0;
    sendCmd(2'd1, 32'h0, 32'h0, 1'b1);
    check("R5 count", count, 0);
    check("R5 overflow", overflow, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check("R1 count", count, 0);
    check("R1 flags", {busy, wrValid, overflow}, 3'b000);
    rstN = 1'b1;
    @(negedge clk);

    // R2 / R3
    record(32'h0000_1000, 32'h1111_0001, 1, "R2");
    record(32'h0000_1004, 32'h1111_0002, 1, "R2");
    record(32'h0000_8000, 32'hDEAD_0000, 0, "R3");
    record(32'h0000_101C, 32'h1111_0003, 1, "R2");
    record(32'h0000_2000, 32'h2222_0001, 1, "R2");

    // R6: line 0x1000 replays three stores oldest first
    inval(32'h0000_1010, "R6");

    // R4: fill and overflow
    record(32'h0000_3000, 32'h3333_0001, 1, "R2");
    record(32'h0000_2008, 32'h2222_0002, 1, "R2");
    record(32'h0000_1FE0, 32'h1FE0_0001, 1, "R2");
    record(32'h0000_4000, 32'h4444_0001, 1, "R4");
    check("R4 sticky", overflow, 1'b1);

    // R7 with random ready: middle entries leave, survivors keep order
    readyMode = 1;
    inval(32'h0000_201F, "R7");
    inval(32'h0000_1FFF, "R7 boundary");
    // R10: no match
    inval(32'h0000_5000, "R10");
    // R10: code 3
    sendCmd(2'd3, 32'h0000_3000, 32'h0, 1'b1);
    check("R10 none count", count, model.size());
    check("R4 still sticky", overflow, 1'b1);
    inval(32'h0000_3004, "R7 last");
    discard();
    inval(32'h0000_3000, "R10 empty");

    // R9: stall, offer a command while busy
    readyMode = 0;
    record(32'h0000_5000, 32'h5555_0001, 1, "R2");
    record(32'h0000_5004, 32'h5555_0002, 1, "R2");
    readyMode = 2;
    planInval(32'h0000_5000);
    sendCmd(2'd2, 32'h0000_5000, 32'h0, 1'b0);
    repeat (3) @(negedge clk);
    check("R9 busy", busy, 1'b1);
    check("R8 stalled request", {wrValid, wrAddr}, {1'b1, 32'h0000_5000});
    cmdOp = 2'd0; cmdAddr = 32'h0000_6000; cmdData = 32'h6666_0001;
    cmdCacheable = 1'b1; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    check("R9 ignored while busy", count, 2);
    readyMode = 1;
    while (busy) @(negedge clk);
    check("R9 count after scan", count, 0);
    check("R9 all writes seen", expQ.size(), 0);
    @(negedge clk);
    check("R9 idle", {busy, wrValid}, 2'b00);

    // R4 at full with discard in between
    readyMode = 0;
    for (int i = 0; i < DEPTH + 1; i++)
      record(32'h0000_7000 + 32'(i * 4), 32'h7000_0000 + 32'(i), 1, "R4");
    inval(32'h0000_7000, "R6 full");
    discard();

    done = 1;
    summary();
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end
endmodule